// File: doc/BRIEF.md
# Stop Mode Wake Recovery Controller

This block runs the low-power stop sequence of a small microcontroller system. A one-cycle stop request from the CPU turns off two clock enables: one for the CPU and bus, and one for the peripherals. Both stay off until a wake source appears. A pending interrupt wakes the block, but the clocks come back only after a recovery interval, timed on the oscillator clock, has fully run. In the cycle the clocks return, the block gives the CPU a one-cycle permission pulse to begin interrupt stacking. An asynchronous reset also ends the stop, and it skips the recovery interval.

A single counter serves the whole sequence. It is held at zero while the block runs and while it is stopped. It counts only during recovery. The recovery length is either long or short. A configuration input picks which one, and the block captures that input at the moment of the stop request.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After reset, both clock enables are 1 and the stacking pulse is 0.
- R2: When the stop request is high at a clock edge while the block is running, both clock enables are 0 from that edge onward.
- R3: While stopped with no interrupt pending, both enables stay 0 and no stacking pulse appears, however long the wait lasts. The counter is held at zero throughout.
- R4: With the short-recovery input at 0 when the stop was requested, the enables stay 0 for exactly 4096 clock cycles after the edge that samples the interrupt.
- R5: With the short-recovery input at 1 when the stop was requested, that interval is exactly 32 cycles.
- R6: The stacking pulse is high for exactly one cycle. That cycle is the first cycle in which the enables are 1 again.
- R7: The short-recovery input is captured with the stop request. Changes to it during the stop or the recovery do not alter the interval.
- R8: An interrupt that is already pending when the stop request arrives still produces the stop and the full recovery interval.
- R9: Reset during the stop or the recovery returns the block at once to running, with enables at 1 and no stacking pulse. The next stop then times a full interval.
- R10: A stop request that arrives while the block is stopped or recovering has no effect. The interval runs to its normal length.
- R11: Once recovery has started, dropping the interrupt request does not end or shorten it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_req_i | input | 1 | Stop request strobe from the CPU |
| irq_pend_i | input | 1 | Any module interrupt pending |
| short_rec_i | input | 1 | 1 selects the short recovery interval |
| cpu_clk_en_o | output | 1 | CPU and bus clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| stack_go_o | output | 1 | One-cycle permission to begin interrupt stacking |

## Verification
Any fault in the state register or in the counter shows up at the ports as a change in the number of cycles the enables stay low. An off-by-one terminal count makes the interval one cycle longer or shorter. A counter that is not cleared shortens the next interval. A wrong captured length selects 32 where 4096 was chosen, or the reverse. Each of these faults is visible by the end of the first recovery it affects. A stacking pulse that is late, doubled or missing is visible in the cycle where the enables rise, or in the cycle after it.

// File: rtl/stop_wake_pkg.sv
package stop_wake_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_STOPPED = 2'd1,
        ST_RECOVER = 2'd2
    } wake_state_e;
endpackage

// File: rtl/wake_counter.sv
module wake_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] count_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)     cnt_d = '0;
        else if (step_i) cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/stop_seq.sv
module stop_seq
    import stop_wake_pkg::*;
#(
    parameter int LONG_CYCLES  = 4096,
    parameter int SHORT_CYCLES = 32,
    parameter int CNT_W        = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             stop_req_i,
    input  logic             irq_i,
    input  logic             short_cfg_i,
    input  logic [CNT_W-1:0] count_i,
    output wake_state_e      state_o,
    output logic             cnt_clear_o,
    output logic             cnt_step_o,
    output logic             clk_en_o,
    output logic             stack_go_o
);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYCLES - 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYCLES - 1);

    typedef struct packed {
        wake_state_e state;
        logic        short_sel;
        logic        stack_go;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      term;

    assign term = (r_q.state == ST_RECOVER) &&
                  (count_i == (r_q.short_sel ? SHORT_LAST : LONG_LAST));

    always_comb begin
        r_d          = r_q;
        r_d.stack_go = 1'b0;
        unique case (r_q.state)
            ST_RUN: begin
                if (stop_req_i) begin
                    r_d.state     = ST_STOPPED;
                    r_d.short_sel = short_cfg_i;
                end
            end
            ST_STOPPED: begin
                if (irq_i) r_d.state = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (term) begin
                    r_d.state    = ST_RUN;
                    r_d.stack_go = 1'b1;
                end
            end
            default: r_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '{state: ST_RUN, short_sel: 1'b0, stack_go: 1'b0};
        else         r_q <= r_d;
    end

    assign state_o     = r_q.state;
    assign cnt_step_o  = (r_q.state == ST_RECOVER) && !term;
    assign cnt_clear_o = (r_q.state != ST_RECOVER) || term;
    assign clk_en_o    = (r_q.state == ST_RUN);
    assign stack_go_o  = r_q.stack_go;

    assert_stack_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.stack_go |=> !r_q.stack_go);
    assert_stack_with_clocks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.stack_go |-> clk_en_o);
    assert_cfg_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state != ST_RUN) |=> (r_q.state == ST_RUN || $stable(r_q.short_sel)));
    assert_no_early_exit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_RECOVER && count_i != SHORT_LAST && count_i != LONG_LAST)
        |=> (r_q.state == ST_RECOVER));
    assert_stop_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_STOPPED && !irq_i) |=> (r_q.state == ST_STOPPED));
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
    import stop_wake_pkg::*;
#(
    parameter int LONG_CYCLES  = 4096,
    parameter int SHORT_CYCLES = 32
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic stop_req_i,
    input  logic irq_pend_i,
    input  logic short_rec_i,
    output logic cpu_clk_en_o,
    output logic per_clk_en_o,
    output logic stack_go_o
);
    localparam int CNT_W = (LONG_CYCLES > 2) ? $clog2(LONG_CYCLES) : 1;

    logic [CNT_W-1:0] count;
    logic             cnt_clear, cnt_step, clk_en;
    wake_state_e      state;

    wake_counter #(.CNT_W(CNT_W)) u_counter (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (cnt_clear),
        .step_i  (cnt_step),
        .count_o (count)
    );

    stop_seq #(
        .LONG_CYCLES (LONG_CYCLES),
        .SHORT_CYCLES(SHORT_CYCLES),
        .CNT_W       (CNT_W)
    ) u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .stop_req_i  (stop_req_i),
        .irq_i       (irq_pend_i),
        .short_cfg_i (short_rec_i),
        .count_i     (count),
        .state_o     (state),
        .cnt_clear_o (cnt_clear),
        .cnt_step_o  (cnt_step),
        .clk_en_o    (clk_en),
        .stack_go_o  (stack_go_o)
    );

    assign cpu_clk_en_o = clk_en;
    assign per_clk_en_o = clk_en;

    assert_count_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_STOPPED) |-> (count == '0));
    assert_count_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_RECOVER) |=> (state == ST_RUN || count == $past(count) + CNT_W'(1)));
    assert_run_cleared_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_RUN) |-> (count == '0));
endmodule

// File: tb/stop_wake_ctrl_bench.sv
`timescale 1ns/1ps
module stop_wake_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 1'b0, irq = 1'b0, short_rec = 1'b0;
    logic cpu_en, per_en, stack_go;
    int   n_cmp = 0, n_bad = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    stop_wake_ctrl u_stop_wake_ctrl (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .stop_req_i  (stop_req),
        .irq_pend_i  (irq),
        .short_rec_i (short_rec),
        .cpu_clk_en_o(cpu_en),
        .per_clk_en_o(per_en),
        .stack_go_o  (stack_go)
    );

    function automatic int exp_len(bit short_sel);
        return short_sel ? 32 : 4096;
    endfunction

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One stop/recovery sequence; returns the measured low-enable length.
    task automatic run_seq(bit short_sel, bit irq_pre, int idle, bit flip_cfg,
                           bit stop_in_rec, bit drop_irq);
        int len;
        stop_req  = 1'b1;
        short_rec = short_sel;
        irq       = irq_pre;
        @(posedge clk); @(negedge clk);
        check("R2 cpu enable off", cpu_en, 0);
        check("R2 peripheral enable off", per_en, 0);
        stop_req = 1'b0;
        if (flip_cfg) short_rec = ~short_sel;
        if (!irq_pre) begin
            for (int i = 0; i < idle; i++) begin
                @(posedge clk); @(negedge clk);
            end
            if (idle > 0) begin
                check("R3 enables held off while stopped", cpu_en | per_en, 0);
                check("R3 no stacking while stopped", stack_go, 0);
            end
            irq = 1'b1;
        end
        len = 0;
        for (int k = 0; k < 5000; k++) begin
            @(posedge clk); @(negedge clk);
            if (cpu_en) break;
            len++;
            if (drop_irq && len == 2) irq = 1'b0;
            if (stop_in_rec && len == 3) stop_req = 1'b1;
            if (stop_in_rec && len == 4) stop_req = 1'b0;
        end
        stop_req = 1'b0;
        irq = 1'b0;
        if (short_sel) check("R5 short interval length", len, exp_len(1'b1));
        else           check("R4 long interval length", len, exp_len(1'b0));
        if (flip_cfg)    check("R7 config change ignored", len, exp_len(short_sel));
        if (irq_pre)     check("R8 pre-pending interrupt full length", len, exp_len(short_sel));
        if (stop_in_rec) check("R10 stop request ignored in recovery", len, exp_len(short_sel));
        if (drop_irq)    check("R11 dropped interrupt keeps recovery", len, exp_len(short_sel));
        check("R6 stacking pulse with clocks", stack_go, 1);
        check("R6 peripheral enable back", per_en, 1);
        @(posedge clk); @(negedge clk);
        check("R6 stacking pulse single cycle", stack_go, 0);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        #1;
        check("R1 cpu enable at reset", cpu_en, 1);
        check("R1 peripheral enable at reset", per_en, 1);
        check("R1 no stacking at reset", stack_go, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners
        run_seq(1'b0, 1'b0, 3, 1'b0, 1'b0, 1'b0);   // R4 long
        run_seq(1'b1, 1'b0, 150, 1'b0, 1'b0, 1'b0); // R3 long idle, R5
        run_seq(1'b1, 1'b0, 2, 1'b1, 1'b0, 1'b0);   // R7 short then flip
        run_seq(1'b0, 1'b0, 2, 1'b1, 1'b0, 1'b0);   // R7 long then flip
        run_seq(1'b1, 1'b1, 0, 1'b0, 1'b0, 1'b0);   // R8
        run_seq(1'b0, 1'b1, 0, 1'b0, 1'b0, 1'b0);   // R8 long
        run_seq(1'b1, 1'b0, 1, 1'b0, 1'b1, 1'b1);   // R10, R11

        // R9: reset during recovery
        stop_req = 1'b1; short_rec = 1'b0; @(negedge clk);
        stop_req = 1'b0; irq = 1'b1;
        repeat (40) @(negedge clk);
        rst_n = 1'b0; irq = 1'b0;
        #1;
        check("R9 reset in recovery restores cpu enable", cpu_en, 1);
        check("R9 reset in recovery restores peripheral enable", per_en, 1);
        check("R9 no stacking after reset", stack_go, 0);
        @(negedge clk); rst_n = 1'b1; @(negedge clk);
        run_seq(1'b1, 1'b0, 1, 1'b0, 1'b0, 1'b0);

        // R9: reset while stopped
        stop_req = 1'b1; short_rec = 1'b1; @(negedge clk);
        stop_req = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R9 reset while stopped restores enable", cpu_en, 1);
        @(negedge clk); rst_n = 1'b1; @(negedge clk);
        check("R9 running after release", cpu_en, 1);

        // Random sequences
        for (int n = 0; n < 24; n++) begin
            bit s   = ($urandom_range(0, 3) != 0);
            bit pre = $urandom_range(0, 1);
            int idl = pre ? 0 : $urandom_range(0, 20);
            run_seq(s, pre, idl, $urandom_range(0, 1), $urandom_range(0, 1),
                    $urandom_range(0, 1));
            repeat ($urandom_range(0, 4)) @(negedge clk);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule